// File: doc/BRIEF.md
# Offset-Calibrated Envelope Smoother

This block turns a stream of unsigned, offset-biased samples into a smoothed magnitude envelope. It sits after a band-pass filter, whose output is centred on an unknown DC level, and before a threshold detector. While an operator holds a zeroing button, the block measures that DC level as the mean of a fixed number of incoming samples. It then stores the result as the reference offset.

Each accepted sample is full-wave rectified as its absolute distance from the stored offset. The rectified value enters a circular history of 2^AVG_LOG2 entries. A running sum is updated in constant time: the entry about to be overwritten is subtracted and the new value is added. The envelope is that sum divided by the history length, which is a plain right shift. Every input sample produces exactly one envelope sample, two clock cycles later.

Top module: `envelope_rectavg`

## Requirements
- R1: While reset is low and right after it, out_valid is 0 and env_out is 0. The stored offset is zero and the history is empty, so the first sample after reset gives env_out = sample >> AVG_LOG2.
- R2: When a sample is strictly greater than the stored offset, its rectified value is sample minus offset.
- R3: When a sample is less than or equal to the stored offset, its rectified value is offset minus sample, so a sample equal to the offset contributes 0.
- R4: With N = 2^AVG_LOG2, env_out is floor(S / N), where S is the sum of the last N rectified values. History slots not yet written since reset count as 0.
- R5: The history is circular. The (N+1)-th sample replaces the first, and from then on each new sample evicts the value that entered N samples earlier.
- R6: When 2^CAL_LOG2 accepted samples arrive in a row while cal_btn stays high, the offset becomes floor of their mean. The sample that completes the window is still rectified with the old offset, and the new offset applies from the next sample. If the button stays held, a fresh window begins.
- R7: A cycle with cal_btn low discards any partial calibration window and leaves the stored offset unchanged.
- R8: out_valid is high for exactly one cycle per accepted sample, two clock edges after the cycle in which in_valid was high. Back-to-back samples give back-to-back outputs.
- R9: In cycles with no sample in flight, env_out holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_sample for one cycle |
| in_sample | input | DW | Unsigned offset-biased sample |
| cal_btn | input | 1 | Offset zeroing request, level sensitive |
| out_valid | output | 1 | Strobe for env_out |
| env_out | output | DW | Smoothed rectified envelope |

## Verification
The bench builds the block with DW = 12, AVG_LOG2 = 2 and CAL_LOG2 = 2. A four-entry history and a four-sample calibration window put ring wraparound, the empty-history start and complete calibration windows within a few dozen samples, while full-scale 12-bit values still exercise the sum width. An aborted window followed by a full one shows whether partial counts leak across a button release. A back-to-back burst and a mid-run reset cover latency and the clearing of offset and history.

// File: rtl/envelope_pkg.sv
package envelope_pkg;

   // unsigned distance between two equal-width values
   function automatic logic [23:0] abs_gap(input logic [23:0] a, input logic [23:0] b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/offset_learn.sv
module offset_learn #(
   parameter int DW       = 12,
   parameter int CAL_LOG2 = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_data,
   input  logic          cal_btn,
   output logic [DW-1:0] offset
);
   localparam int AW = DW + CAL_LOG2;

   logic [CAL_LOG2-1:0] cnt_q;
   logic [AW-1:0]       acc_q;
   logic [AW-1:0]       acc_d;

   assign acc_d = acc_q + AW'(in_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         offset <= '0;
      end else if (!cal_btn) begin
         cnt_q <= '0;
         acc_q <= '0;
      end else if (in_vld) begin
         if (cnt_q == '1) begin
            offset <= acc_d[AW-1:CAL_LOG2];
            cnt_q  <= '0;
            acc_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= acc_d;
         end
      end
   end
endmodule

// File: rtl/rectify_stage.sv
module rectify_stage
   import envelope_pkg::*;
#(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_data,
   input  logic [DW-1:0] offset,
   output logic          rect_vld,
   output logic [DW-1:0] rect_val
);
   logic [23:0] gap;

   assign gap = abs_gap(24'(in_data), 24'(offset));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rect_vld <= 1'b0;
         rect_val <= '0;
      end else begin
         rect_vld <= in_vld;
         if (in_vld) rect_val <= gap[DW-1:0];
      end
   end
endmodule

// File: rtl/ring_average.sv
module ring_average #(
   parameter int DW       = 12,
   parameter int AVG_LOG2 = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_val,
   output logic          out_vld,
   output logic [DW-1:0] out_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   generate
      if (AVG_LOG2 == 0) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      out_val <= '0;
            else if (in_vld) out_val <= in_val;
         end
      end else begin : g_ring
         localparam int DEPTH = 1 << AVG_LOG2;
         localparam int SW    = DW + AVG_LOG2;

         logic [DW-1:0]       hist [DEPTH];
         logic [AVG_LOG2-1:0] wr_idx;
         logic                wrapped;
         logic [SW-1:0]       sum_q;
         logic [SW-1:0]       sum_d;
         logic [DW-1:0]       oldest;

         // slots never written since reset read as zero
         assign oldest = wrapped ? hist[wr_idx] : '0;
         assign sum_d  = sum_q - SW'(oldest) + SW'(in_val);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_idx  <= '0;
               wrapped <= 1'b0;
               sum_q   <= '0;
               out_val <= '0;
            end else if (in_vld) begin
               sum_q   <= sum_d;
               out_val <= sum_d[SW-1:AVG_LOG2];
               wr_idx  <= wr_idx + 1'b1;
               if (wr_idx == '1) wrapped <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (in_vld) hist[wr_idx] <= in_val;
         end
      end
   endgenerate
endmodule

// File: rtl/envelope_rectavg.sv
module envelope_rectavg #(
   parameter int DW       = 12,
   parameter int AVG_LOG2 = 9,
   parameter int CAL_LOG2 = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_sample,
   input  logic          cal_btn,
   output logic          out_valid,
   output logic [DW-1:0] env_out
);
   generate
      if (DW < 2 || DW > 24) begin : g_bad_dw
         $error("envelope_rectavg: DW must lie in 2..24");
      end
      if (AVG_LOG2 < 0 || AVG_LOG2 > 12) begin : g_bad_avg
         $error("envelope_rectavg: AVG_LOG2 must lie in 0..12");
      end
      if (CAL_LOG2 < 1 || CAL_LOG2 > 16) begin : g_bad_cal
         $error("envelope_rectavg: CAL_LOG2 must lie in 1..16");
      end
   endgenerate

   logic [DW-1:0] offset_q;
   logic          rect_vld;
   logic [DW-1:0] rect_val;

   offset_learn #(.DW(DW), .CAL_LOG2(CAL_LOG2)) u_cal (
      .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .in_data(in_sample),
      .cal_btn(cal_btn), .offset(offset_q)
   );

   rectify_stage #(.DW(DW)) u_rect (
      .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .in_data(in_sample),
      .offset(offset_q), .rect_vld(rect_vld), .rect_val(rect_val)
   );

   ring_average #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_avg (
      .clk(clk), .rst_n(rst_n), .in_vld(rect_vld), .in_val(rect_val),
      .out_vld(out_valid), .out_val(env_out)
   );
endmodule

// File: rtl/envelope_rectavg_chk.sv
module envelope_rectavg_chk #(
   parameter int DW       = 12,
   parameter int CAL_LOG2 = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          cal_btn,
   input logic          out_valid,
   input logic [DW-1:0] env_out,
   input logic [DW-1:0] offset
);
   logic [1:0]          vld_pipe;
   logic [CAL_LOG2-1:0] win_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_pipe <= '0;
         win_cnt  <= '0;
      end else begin
         vld_pipe <= {vld_pipe[0], in_valid};
         if (!cal_btn)      win_cnt <= '0;
         else if (in_valid) win_cnt <= win_cnt + 1'b1;
      end
   end

   // R8: one strobe per sample, two edges later
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vld_pipe[1]);

   // R9: nothing in flight leaves the envelope untouched
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_pipe[0] |=> $stable(env_out));

   // R7: released button never moves the offset
   p_offset_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_btn |=> $stable(offset));

   // R6: offset moves only on the sample that closes a full window
   p_offset_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid || win_cnt != '1) |=> $stable(offset));
endmodule

bind envelope_rectavg envelope_rectavg_chk #(.DW(DW), .CAL_LOG2(CAL_LOG2)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cal_btn(cal_btn),
   .out_valid(out_valid), .env_out(env_out), .offset(offset_q)
);

// File: tb/envelope_rectavg_test.sv
module envelope_rectavg_test;
   localparam int DW = 12;
   localparam int AVG_LOG2 = 2;
   localparam int CAL_LOG2 = 2;
   localparam int VEC_N = 24;

   // vectors 1-6: offset 0, fill and wrap (R1 R2 R4 R5)
   // vectors 7-10: full calibration window, offset -> 1006 (R6)
   // vectors 11-14: above / below / equal to offset (R2 R3)
   // vectors 15-18: partial window then release, offset kept (R7)
   // vectors 19-24: full window, offset -> 2000 (R6)
   localparam int V_SMP [VEC_N] = '{100, 200, 7, 1, 400, 4095,
                                    1000, 1004, 1008, 1012,
                                    1106, 906, 1006, 0,
                                    3000, 3000, 3000, 1006,
                                    2000, 2000, 2000, 2000, 2000, 2100};
   localparam int V_BTN [VEC_N] = '{0, 0, 0, 0, 0, 0,
                                    1, 1, 1, 1,
                                    0, 0, 0, 0,
                                    1, 1, 0, 0,
                                    1, 1, 1, 1, 0, 0};
   localparam int V_EXP [VEC_N] = '{25, 75, 76, 77, 152, 1125,
                                    1374, 1624, 1776, 1006,
                                    781, 555, 303, 301,
                                    775, 1248, 1747, 1495,
                                    1245, 995, 745, 994, 745, 522};
   localparam int V_REQ [VEC_N] = '{1, 4, 4, 4, 5, 5,
                                    6, 6, 6, 6,
                                    2, 3, 3, 3,
                                    7, 7, 7, 7,
                                    6, 6, 6, 6, 6, 6};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_sample = '0;
   logic          cal_btn = 1'b0;
   logic          out_valid;
   logic [DW-1:0] env_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   envelope_rectavg #(.DW(DW), .AVG_LOG2(AVG_LOG2), .CAL_LOG2(CAL_LOG2)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cal_btn(cal_btn), .out_valid(out_valid), .env_out(env_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send(input int smp, input int btn, input int exp, input string tag);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = DW'(smp);
      cal_btn   = btn[0];
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk({tag, " valid"}, int'(out_valid), 1);
      chk({tag, " env"}, int'(env_out), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: state under reset
      repeat (3) @(negedge clk);
      chk("R1 reset valid", int'(out_valid), 0);
      chk("R1 reset env", int'(env_out), 0);
      rst_n = 1'b1;

      for (int i = 0; i < VEC_N; i++) begin
         send(V_SMP[i], V_BTN[i], V_EXP[i], $sformatf("R%0d vec%0d", V_REQ[i], i + 1));
      end

      // R9: idle cycles hold the output
      repeat (10) @(negedge clk);
      chk("R9 idle valid", int'(out_valid), 0);
      chk("R9 idle env", int'(env_out), 522);

      // R8: burst of samples with offset 2000, each rectifies to 0
      @(negedge clk);
      in_valid = 1'b1; in_sample = 12'd2000;
      @(negedge clk);
      chk("R8 no output after one edge", int'(out_valid), 0);
      @(negedge clk);
      chk("R8 burst out1 valid", int'(out_valid), 1);
      chk("R8 burst out1 env", int'(env_out), 273);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R8 burst out2 valid", int'(out_valid), 1);
      chk("R8 burst out2 env", int'(env_out), 25);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 gap cycle valid", int'(out_valid), 0);
      @(negedge clk);
      chk("R8 burst out3 valid", int'(out_valid), 1);
      chk("R8 burst out3 env", int'(env_out), 25);
      @(negedge clk);
      chk("R8 strobe single", int'(out_valid), 0);

      // R1: mid-run reset clears offset and history
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 midrun reset valid", int'(out_valid), 0);
      chk("R1 midrun reset env", int'(env_out), 0);
      rst_n = 1'b1;
      send(40, 0, 10, "R1 first after reset");
      send(0, 0, 10, "R4 empty slot 2");
      send(0, 0, 10, "R4 empty slot 3");
      send(0, 0, 10, "R4 empty slot 4");
      send(0, 0, 0, "R5 first eviction");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule